// File: doc/BRIEF.md
# Memory Burst Read/Write Adapter

This block sits between request logic running on the user clock and the native application port of a DDR-style memory controller. One user request always moves a whole burst: eight consecutive 16-bit words starting at an address aligned to eight words. The adapter issues the command and write data the controller expects and waits for each handshake. For reads it builds a single 128-bit result and keeps it after the controller's data has gone away.

The controller can run at one of two clock ratios. In the full-width (4:1) ratio, one command and one 128-bit data beat carry the whole burst. In the split (2:1) ratio, the burst travels as two 64-bit halves. The adapter issues two commands, the second four words above the first, and moves two data beats, lower half first. A mode input selects the ratio for each request. Read data from the controller is valid only in the cycles where its valid strobe is high, which can be as short as one or two cycles. The adapter therefore captures on the strobe alone and ignores the data bus at all other times.

Only one request is in flight at a time. `busy_o` covers the request from acceptance to completion, and `done_o` marks the end.

Top module: `mem_burst_adapter`

## Requirements
- R1: During and straight after reset, `busy_o`, `done_o`, `ctl_cmd_valid_o` and `ctl_wvalid_o` are 0 and `rd_data_o` is all zeros.
- R2: A request is taken at a clock edge where `req_valid_i` is 1 and `busy_o` is 0. `busy_o` is 1 from the next cycle until the request completes. `req_valid_i` has no effect while `busy_o` is 1, and no command or write beat is presented while `busy_o` is 0.
- R3: The low three bits of `req_addr_i` are ignored. Every command address is the request address with those bits cleared, plus the beat offset. In full mode (`mode_half_i`=0) exactly one command is issued, at that base address.
- R4: In split mode (`mode_half_i`=1) exactly two commands are issued, at base and then base+4, in that order. Write data goes out as two beats: bits [63:0] of the request data, then bits [127:64]. Each beat sits in `ctl_wdata_o[63:0]`, and `ctl_wdata_o[127:64]` is zero.
- R5: In full mode a write is one 128-bit beat, equal to `req_wdata_i`. `ctl_wend_o` is 1 exactly on the last write beat of a request and never without `ctl_wvalid_o`.
- R6: While `ctl_cmd_valid_o` is 1 and `ctl_rdy_i` is 0, the command stays presented with the same address and direction on the next cycle. While `ctl_wvalid_o` is 1 and `ctl_wrdy_i` is 0, the write beat and `ctl_wend_o` stay unchanged on the next cycle.
- R7: `ctl_rdata_i` is sampled only in cycles with `ctl_rvalid_i`=1, and only as a beat of the current read whose command has already been accepted. Strobes while idle, strobes before the command is accepted, and strobes beyond the expected beat count leave `rd_data_o` unchanged.
- R8: A split-mode read places the first returned beat's bits [63:0] in `rd_data_o[63:0]` and the second beat's bits [63:0] in `rd_data_o[127:64]`. It completes only after both beats. A full-mode read returns the single 128-bit beat.
- R9: `rd_data_o` changes only in the cycle where `done_o` is 1 at the end of a read. Writes and idle cycles leave it unchanged.
- R10: `mode_half_i` is sampled only when a request is accepted. Changing it while busy does not alter the request in progress.
- R11: `done_o` is a one-cycle pulse in the cycle after the last handshake or read beat of a request, and `busy_o` is 0 in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | User clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_half_i | input | 1 | 1 = split 2:1 ratio, 0 = full 4:1 ratio, sampled on acceptance |
| req_valid_i | input | 1 | Request strobe |
| req_write_i | input | 1 | 1 = write burst, 0 = read burst |
| req_addr_i | input | 28 | Word address of the burst (low 3 bits ignored) |
| req_wdata_i | input | 128 | Eight words of write data, lowest address in bits [15:0] |
| busy_o | output | 1 | Request in flight |
| done_o | output | 1 | One-cycle completion pulse |
| rd_data_o | output | 128 | Last completed read burst, held |
| ctl_cmd_valid_o | output | 1 | Command presented to the controller |
| ctl_cmd_write_o | output | 1 | Command direction |
| ctl_addr_o | output | 28 | Command word address |
| ctl_rdy_i | input | 1 | Controller accepts the command |
| ctl_wvalid_o | output | 1 | Write beat presented |
| ctl_wdata_o | output | 128 | Write beat data |
| ctl_wend_o | output | 1 | Last write beat of the request |
| ctl_wrdy_i | input | 1 | Controller accepts the write beat |
| ctl_rvalid_i | input | 1 | Read beat strobe |
| ctl_rdata_i | input | 128 | Read beat data, meaningful only with the strobe |

## Verification
The bench builds the block with its default parameters: 16-bit words, eight-word bursts, two beats in split mode and 28-bit addresses. With these values both ratios can be exercised against one word-addressed model memory, so data written in one mode is read back in the other. The half-boundary placement at bit 64 and the base+4 step of the second command are observable directly. The controller model stalls the two handshakes independently, holds a read strobe for two cycles and injects strobes with junk data, which brings the hold, capture and ignore rules within reach.

// File: rtl/mba_pkg.sv
`timescale 1ns/1ps
package mba_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} mba_state_e;
  typedef enum logic {RATIO_FULL = 1'b0, RATIO_SPLIT = 1'b1} mba_ratio_e;
endpackage

// File: rtl/mba_cmd_seq.sv
`timescale 1ns/1ps
module mba_cmd_seq
  import mba_pkg::*;
#(
  parameter int ADDR_W      = 28,
  parameter int BURST_LEN   = 8,
  parameter int SPLIT_BEATS = 2,
  parameter int CNT_W       = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              mode_half_i,
  input  logic              ctl_rdy_i,
  input  logic              wr_done_i,
  input  logic              rd_done_i,
  output logic              start_o,
  output logic              active_o,
  output logic              write_o,
  output logic              half_o,
  output logic [CNT_W-1:0]  beats_o,
  output logic [CNT_W-1:0]  issued_o,
  output logic              finish_o,
  output logic              cmd_valid_o,
  output logic              cmd_write_o,
  output logic [ADDR_W-1:0] cmd_addr_o
);
  localparam int STEP     = BURST_LEN / SPLIT_BEATS;
  localparam int STEP_LSB = $clog2(STEP);

  mba_state_e        state_q;
  mba_ratio_e        ratio_q;
  logic              write_q;
  logic [ADDR_W-1:0] base_q;
  logic [CNT_W-1:0]  cnt_q, cnt_n, beats;
  logic              fire;

  always_comb beats = (ratio_q == RATIO_SPLIT) ? CNT_W'(SPLIT_BEATS) : CNT_W'(1);

  assign active_o    = (state_q == ST_RUN);
  assign start_o     = !active_o && req_valid_i;
  assign cmd_valid_o = active_o && (cnt_q < beats);
  assign fire        = cmd_valid_o && ctl_rdy_i;
  assign cnt_n       = cnt_q + CNT_W'(fire);
  // completion needs every command accepted plus the data side finished
  assign finish_o    = active_o && (cnt_n == beats) && (write_q ? wr_done_i : rd_done_i);
  assign cmd_write_o = write_q;
  assign cmd_addr_o  = base_q + (ADDR_W'(cnt_q) << STEP_LSB);
  assign write_o     = write_q;
  assign half_o      = (ratio_q == RATIO_SPLIT);
  assign beats_o     = beats;
  assign issued_o    = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ratio_q <= RATIO_FULL;
      write_q <= 1'b0;
      base_q  <= '0;
      cnt_q   <= '0;
    end else if (start_o) begin
      state_q <= ST_RUN;
      ratio_q <= mode_half_i ? RATIO_SPLIT : RATIO_FULL;
      write_q <= req_write_i;
      base_q  <= req_addr_i & ~ADDR_W'(BURST_LEN - 1);
      cnt_q   <= '0;
    end else if (active_o) begin
      cnt_q <= cnt_n;
      if (finish_o) state_q <= ST_IDLE;
    end
  end
endmodule

// File: rtl/mba_wr_path.sv
`timescale 1ns/1ps
module mba_wr_path #(
  parameter int DATA_W      = 128,
  parameter int SPLIT_BEATS = 2,
  parameter int CNT_W       = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              active_i,
  input  logic              write_i,
  input  logic              half_i,
  input  logic [CNT_W-1:0]  beats_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic              ctl_wrdy_i,
  output logic              done_n_o,
  output logic              wvalid_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              wend_o
);
  localparam int HALF_W = DATA_W / SPLIT_BEATS;

  logic [DATA_W-1:0] data_q;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [HALF_W-1:0] slice [SPLIT_BEATS];
  logic [HALF_W-1:0] beat;
  logic              fire;

  for (genvar g = 0; g < SPLIT_BEATS; g++) begin : g_slice
    assign slice[g] = data_q[g*HALF_W +: HALF_W];
  end

  always_comb begin
    beat = '0;
    for (int g = 0; g < SPLIT_BEATS; g++)
      if (cnt_q == CNT_W'(g)) beat = slice[g];
  end

  assign wvalid_o = active_i && write_i && (cnt_q < beats_i);
  assign fire     = wvalid_o && ctl_wrdy_i;
  assign cnt_n    = cnt_q + CNT_W'(fire);
  assign done_n_o = (cnt_n == beats_i);
  assign wend_o   = wvalid_o && (cnt_q == beats_i - CNT_W'(1));
  assign wdata_o  = half_i ? {{(DATA_W-HALF_W){1'b0}}, beat} : data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      cnt_q  <= '0;
    end else if (start_i) begin
      data_q <= req_wdata_i;
      cnt_q  <= '0;
    end else if (fire) begin
      cnt_q <= cnt_n;
    end
  end
endmodule

// File: rtl/mba_rd_capture.sv
`timescale 1ns/1ps
module mba_rd_capture #(
  parameter int DATA_W      = 128,
  parameter int SPLIT_BEATS = 2,
  parameter int CNT_W       = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              active_i,
  input  logic              write_i,
  input  logic              half_i,
  input  logic [CNT_W-1:0]  beats_i,
  input  logic [CNT_W-1:0]  issued_i,
  input  logic              ctl_rvalid_i,
  input  logic [DATA_W-1:0] ctl_rdata_i,
  output logic              done_n_o,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int HALF_W = DATA_W / SPLIT_BEATS;

  logic [DATA_W-1:0] asm_q, asm_n, out_q;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic              take;

  // a beat counts only against a command already accepted
  assign take     = active_i && !write_i && ctl_rvalid_i && (cnt_q < issued_i);
  assign cnt_n    = cnt_q + CNT_W'(take);
  assign done_n_o = (cnt_n == beats_i);

  always_comb begin
    asm_n = asm_q;
    if (half_i) begin
      for (int g = 0; g < SPLIT_BEATS; g++)
        if (cnt_q == CNT_W'(g)) asm_n[g*HALF_W +: HALF_W] = ctl_rdata_i[HALF_W-1:0];
    end else begin
      asm_n = ctl_rdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      asm_q <= '0;
      out_q <= '0;
      cnt_q <= '0;
    end else if (start_i) begin
      cnt_q <= '0;
    end else if (take) begin
      cnt_q <= cnt_n;
      asm_q <= asm_n;
      if (cnt_n == beats_i) out_q <= asm_n;
    end
  end

  assign rd_data_o = out_q;
endmodule

// File: rtl/mem_burst_adapter.sv
`timescale 1ns/1ps
module mem_burst_adapter #(
  parameter int  WORD_W      = 16,
  parameter int  BURST_LEN   = 8,
  parameter int  SPLIT_BEATS = 2,
  parameter int  ADDR_W      = 28,
  localparam int DATA_W      = WORD_W * BURST_LEN
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_half_i,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              ctl_cmd_valid_o,
  output logic              ctl_cmd_write_o,
  output logic [ADDR_W-1:0] ctl_addr_o,
  input  logic              ctl_rdy_i,
  output logic              ctl_wvalid_o,
  output logic [DATA_W-1:0] ctl_wdata_o,
  output logic              ctl_wend_o,
  input  logic              ctl_wrdy_i,
  input  logic              ctl_rvalid_i,
  input  logic [DATA_W-1:0] ctl_rdata_i
);
  localparam int CNT_W = $clog2(SPLIT_BEATS + 1);

  logic             start, active, write, half, finish;
  logic             wr_done_n, rd_done_n;
  logic [CNT_W-1:0] beats, issued;
  logic             done_q;

  mba_cmd_seq #(
    .ADDR_W(ADDR_W), .BURST_LEN(BURST_LEN), .SPLIT_BEATS(SPLIT_BEATS), .CNT_W(CNT_W)
  ) u_cmd_seq (
    .clk_i, .rst_ni, .req_valid_i, .req_write_i, .req_addr_i, .mode_half_i, .ctl_rdy_i,
    .wr_done_i(wr_done_n), .rd_done_i(rd_done_n),
    .start_o(start), .active_o(active), .write_o(write), .half_o(half),
    .beats_o(beats), .issued_o(issued), .finish_o(finish),
    .cmd_valid_o(ctl_cmd_valid_o), .cmd_write_o(ctl_cmd_write_o), .cmd_addr_o(ctl_addr_o)
  );

  mba_wr_path #(.DATA_W(DATA_W), .SPLIT_BEATS(SPLIT_BEATS), .CNT_W(CNT_W)) u_wr_path (
    .clk_i, .rst_ni, .start_i(start), .active_i(active), .write_i(write), .half_i(half),
    .beats_i(beats), .req_wdata_i, .ctl_wrdy_i, .done_n_o(wr_done_n),
    .wvalid_o(ctl_wvalid_o), .wdata_o(ctl_wdata_o), .wend_o(ctl_wend_o)
  );

  mba_rd_capture #(.DATA_W(DATA_W), .SPLIT_BEATS(SPLIT_BEATS), .CNT_W(CNT_W)) u_rd_capture (
    .clk_i, .rst_ni, .start_i(start), .active_i(active), .write_i(write), .half_i(half),
    .beats_i(beats), .issued_i(issued), .ctl_rvalid_i, .ctl_rdata_i,
    .done_n_o(rd_done_n), .rd_data_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) done_q <= 1'b0;
    else         done_q <= finish;
  end

  assign busy_o = active;
  assign done_o = done_q;
endmodule

// File: rtl/mba_checker.sv
`timescale 1ns/1ps
module mba_checker #(
  parameter int ADDR_W   = 28,
  parameter int DATA_W   = 128,
  parameter int STEP_LSB = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              busy_o,
  input logic              done_o,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              ctl_cmd_valid_o,
  input logic              ctl_cmd_write_o,
  input logic [ADDR_W-1:0] ctl_addr_o,
  input logic              ctl_rdy_i,
  input logic              ctl_wvalid_o,
  input logic [DATA_W-1:0] ctl_wdata_o,
  input logic              ctl_wend_o,
  input logic              ctl_wrdy_i
);
  assert_busy_after_accept_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !busy_o) |=> busy_o);
  assert_idle_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!ctl_cmd_valid_o && !ctl_wvalid_o));
  assert_addr_aligned_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_cmd_valid_o |-> (ctl_addr_o[STEP_LSB-1:0] == '0));
  assert_wend_with_beat_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_wend_o |-> ctl_wvalid_o);
  assert_cmd_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_cmd_valid_o && !ctl_rdy_i) |=>
      (ctl_cmd_valid_o && $stable(ctl_addr_o) && $stable(ctl_cmd_write_o)));
  assert_wbeat_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_wvalid_o && !ctl_wrdy_i) |=>
      (ctl_wvalid_o && $stable(ctl_wdata_o) && $stable(ctl_wend_o)));
  assert_rd_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rd_data_o) |-> done_o);
  assert_done_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  assert_done_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

bind mem_burst_adapter mba_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STEP_LSB($clog2(BURST_LEN / SPLIT_BEATS))
) u_mba_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .busy_o(busy_o),
  .done_o(done_o), .rd_data_o(rd_data_o), .ctl_cmd_valid_o(ctl_cmd_valid_o),
  .ctl_cmd_write_o(ctl_cmd_write_o), .ctl_addr_o(ctl_addr_o), .ctl_rdy_i(ctl_rdy_i),
  .ctl_wvalid_o(ctl_wvalid_o), .ctl_wdata_o(ctl_wdata_o), .ctl_wend_o(ctl_wend_o),
  .ctl_wrdy_i(ctl_wrdy_i)
);

// File: tb/mem_burst_adapter_tb_top.sv
`timescale 1ns/1ps
module mem_burst_adapter_tb_top;
  localparam int ADDR_W = 28;
  localparam int DATA_W = 128;

  logic              clk_i = 1'b0, rst_ni = 1'b0;
  logic              mode_half_i = 1'b0, req_valid_i = 1'b0, req_write_i = 1'b0;
  logic [ADDR_W-1:0] req_addr_i = '0;
  logic [DATA_W-1:0] req_wdata_i = '0;
  logic              busy_o, done_o, ctl_cmd_valid_o, ctl_cmd_write_o;
  logic [DATA_W-1:0] rd_data_o, ctl_wdata_o;
  logic [ADDR_W-1:0] ctl_addr_o;
  logic              ctl_rdy_i = 1'b0, ctl_wvalid_o, ctl_wend_o, ctl_wrdy_i = 1'b0;
  logic              ctl_rvalid_i = 1'b0;
  logic [DATA_W-1:0] ctl_rdata_i = '0;

  mem_burst_adapter dut_i (.*);

  always #4 clk_i = ~clk_i;

  int cyc = 0;
  always @(posedge clk_i) cyc <= cyc + 1;

  int checks = 0, errors = 0;
  task automatic check(input bit ok, input string req, input logic [DATA_W:0] act,
                       input logic [DATA_W:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // word-addressed memories: model side and scoreboard side
  logic [15:0] mem [int];
  logic [15:0] shadow [int];
  function automatic logic [15:0] mem_rd(int a);
    return mem.exists(a) ? mem[a] : 16'h0;
  endfunction
  function automatic logic [15:0] shd_rd(int a);
    return shadow.exists(a) ? shadow[a] : 16'h0;
  endfunction
  function automatic logic [DATA_W-1:0] junk();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  // scoreboard queues
  logic [ADDR_W:0]   exp_cmd_q [$];
  logic [DATA_W:0]   exp_w_q   [$];
  logic [DATA_W-1:0] exp_rd_q  [$];
  bit                exp_op_q  [$];
  logic [DATA_W-1:0] last_rd_exp = '0;

  // controller model knobs
  bit bp = 0, stall_cmd = 0, stray = 0, dbl = 0, model_half = 0;
  int rp_addr [$]; int rp_due [$]; bit rp_half [$];
  int wq_addr [$]; logic [DATA_W-1:0] wq_data [$];

  initial begin
    bit h; int a; logic [DATA_W-1:0] d; bit rep_valid; logic [DATA_W-1:0] rep_data;
    rep_valid = 0; rep_data = '0;
    @(posedge rst_ni);
    forever begin
      @(negedge clk_i);
      ctl_rdy_i  = !stall_cmd && (!bp || (cyc % 3 != 1));
      ctl_wrdy_i = !bp || (cyc % 2 == 0);
      if (rep_valid) begin
        ctl_rvalid_i = 1'b1; ctl_rdata_i = rep_data; rep_valid = 0;
      end else if (rp_addr.size() > 0 && rp_due[0] <= cyc) begin
        h = rp_half.pop_front(); a = rp_addr.pop_front(); void'(rp_due.pop_front());
        d = junk();
        for (int i = 0; i < (h ? 4 : 8); i++) d[16*i +: 16] = mem_rd(a + i);
        ctl_rvalid_i = 1'b1; ctl_rdata_i = d;
        if (dbl && !h) begin rep_valid = 1; rep_data = d; end
      end else begin
        ctl_rvalid_i = stray; ctl_rdata_i = junk();
      end
      #3;
      if (ctl_cmd_valid_o && ctl_rdy_i) begin
        if (ctl_cmd_write_o) wq_addr.push_back(int'(ctl_addr_o));
        else begin
          rp_addr.push_back(int'(ctl_addr_o)); rp_due.push_back(cyc + 3);
          rp_half.push_back(model_half);
        end
      end
      if (ctl_wvalid_o && ctl_wrdy_i) wq_data.push_back(ctl_wdata_o);
      while (wq_addr.size() > 0 && wq_data.size() > 0) begin
        a = wq_addr.pop_front(); d = wq_data.pop_front();
        for (int i = 0; i < (model_half ? 4 : 8); i++) mem[a + i] = d[16*i +: 16];
      end
    end
  end

  // monitor: pops expectations as the design produces results
  initial begin
    bit pc, pw, pd; logic [ADDR_W:0] pa; logic [DATA_W:0] pwd;
    logic [ADDR_W:0] ec; logic [DATA_W:0] ew; bit rd_op; logic [DATA_W-1:0] er;
    pc = 0; pw = 0; pd = 0; pa = '0; pwd = '0;
    @(posedge rst_ni);
    forever begin
      @(negedge clk_i); #3;
      if (pc) check(ctl_cmd_valid_o && {ctl_cmd_write_o, ctl_addr_o} == pa,
                    "R6 command held under stall", {ctl_cmd_write_o, ctl_addr_o}, pa);
      if (pw) check(ctl_wvalid_o && {ctl_wend_o, ctl_wdata_o} == pwd,
                    "R6 write beat held under stall", {ctl_wend_o, ctl_wdata_o}, pwd);
      if (ctl_cmd_valid_o && ctl_rdy_i) begin
        if (exp_cmd_q.size() == 0)
          check(0, "R2 unexpected command", {ctl_cmd_write_o, ctl_addr_o}, '0);
        else begin
          ec = exp_cmd_q.pop_front();
          check({ctl_cmd_write_o, ctl_addr_o} == ec, "R3 R4 command address",
                {ctl_cmd_write_o, ctl_addr_o}, ec);
        end
      end
      if (ctl_wvalid_o && ctl_wrdy_i) begin
        if (exp_w_q.size() == 0)
          check(0, "R2 unexpected write beat", {ctl_wend_o, ctl_wdata_o}, '0);
        else begin
          ew = exp_w_q.pop_front();
          check({ctl_wend_o, ctl_wdata_o} == ew, "R4 R5 write beat",
                {ctl_wend_o, ctl_wdata_o}, ew);
        end
      end
      if (done_o) begin
        check(!pd, "R11 done is one cycle", pd, 0);
        check(!busy_o, "R11 busy low with done", busy_o, 0);
        if (exp_op_q.size() == 0) check(0, "R2 unexpected completion", 1, 0);
        else begin
          rd_op = exp_op_q.pop_front();
          if (rd_op) begin
            er = exp_rd_q.pop_front();
            check(rd_data_o == er, "R8 read result", rd_data_o, er);
            last_rd_exp = er;
          end else
            check(rd_data_o == last_rd_exp, "R9 write leaves read data", rd_data_o, last_rd_exp);
        end
      end
      pc = ctl_cmd_valid_o && !ctl_rdy_i; pa = {ctl_cmd_write_o, ctl_addr_o};
      pw = ctl_wvalid_o && !ctl_wrdy_i;   pwd = {ctl_wend_o, ctl_wdata_o};
      pd = done_o;
    end
  end

  // driver: pushes expectations, then issues the request
  task automatic do_req(input bit wr, input int addr, input logic [DATA_W-1:0] d,
                        input bit half, input bit hold);
    int base; int n; logic [DATA_W-1:0] er;
    @(negedge clk_i);
    while (busy_o) @(negedge clk_i);
    base = addr & ~7; n = half ? 2 : 1;
    for (int b = 0; b < n; b++) exp_cmd_q.push_back({wr, ADDR_W'(base + 4*b)});
    if (wr) begin
      for (int b = 0; b < n; b++)
        exp_w_q.push_back(half ? {b == n-1, 64'h0, d[64*b +: 64]} : {1'b1, d});
      for (int i = 0; i < 8; i++) shadow[base + i] = d[16*i +: 16];
    end else begin
      for (int i = 0; i < 8; i++) er[16*i +: 16] = shd_rd(base + i);
      exp_rd_q.push_back(er);
    end
    exp_op_q.push_back(!wr);
    model_half = half;
    req_valid_i = 1'b1; req_write_i = wr; req_addr_i = ADDR_W'(addr);
    req_wdata_i = d; mode_half_i = half;
    @(negedge clk_i);
    check(busy_o, "R2 busy after accept", busy_o, 1);
    mode_half_i = !half;  // R10: must not affect the request in flight
    if (hold) begin
      req_addr_i = ADDR_W'(addr + 64); req_write_i = !wr; req_wdata_i = junk();
      repeat (2) @(negedge clk_i);
    end
    req_valid_i = 1'b0;
    while (!done_o) @(negedge clk_i);
  endtask

  logic [DATA_W-1:0] pat_a, pat_b;

  initial begin
    repeat (3) @(negedge clk_i);
    check(!busy_o && !done_o && !ctl_cmd_valid_o && !ctl_wvalid_o, "R1 reset outputs",
          {busy_o, done_o, ctl_cmd_valid_o, ctl_wvalid_o}, 0);
    check(rd_data_o == '0, "R1 reset read data", rd_data_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(!busy_o && !ctl_cmd_valid_o, "R1 after reset idle", busy_o, 0);

    for (int i = 0; i < 8; i++) begin
      pat_a[16*i +: 16] = 16'h1100 + 16'(i);
      pat_b[16*i +: 16] = 16'hA5F0 ^ 16'(i * 16'h0101);
    end
    // R3 R5: full-width write and read
    do_req(1, 'h10, pat_a, 0, 0);
    do_req(0, 'h15, '0, 0, 0);
    // R4 R8: split write at an unaligned address, read back in both modes
    do_req(1, 'h23, pat_b, 1, 0);
    do_req(0, 'h20, '0, 1, 0);
    do_req(0, 'h27, '0, 0, 0);
    do_req(0, 'h10, '0, 1, 0);
    // R6: handshake backpressure
    bp = 1;
    do_req(1, 'h40, junk(), 1, 0);
    do_req(1, 'h48, junk(), 0, 0);
    do_req(0, 'h40, '0, 0, 0);
    do_req(0, 'h48, '0, 1, 0);
    bp = 0;
    // R2 R10: request held and mode flipped while busy
    do_req(0, 'h20, '0, 1, 1);
    do_req(0, 'h10, '0, 0, 1);
    // R7: strobes while idle
    @(negedge clk_i); stray = 1;
    repeat (2) @(negedge clk_i); stray = 0;
    repeat (2) @(negedge clk_i);
    check(rd_data_o == last_rd_exp, "R7 idle strobe ignored", rd_data_o, last_rd_exp);
    check(!done_o && !busy_o, "R7 idle strobe no completion", {done_o, busy_o}, 0);
    // R7: strobes before the command is accepted
    fork
      do_req(0, 'h20, '0, 1, 0);
      begin stall_cmd = 1; stray = 1; repeat (4) @(negedge clk_i); stray = 0; stall_cmd = 0; end
    join
    // R7: strobe lasting two cycles on a full read
    dbl = 1;
    do_req(0, 'h48, '0, 0, 0);
    dbl = 0;
    repeat (3) @(negedge clk_i);
    check(rd_data_o == last_rd_exp, "R7 extra strobe ignored", rd_data_o, last_rd_exp);
    // mixed traffic
    for (int k = 0; k < 24; k++) begin
      bp = $urandom % 2;
      do_req($urandom % 2, int'($urandom % 256), junk(), $urandom % 2, 0);
    end
    bp = 0;
    repeat (10) @(negedge clk_i);
    check(exp_cmd_q.size() == 0 && exp_w_q.size() == 0 && exp_op_q.size() == 0,
          "R2 all expected traffic seen", exp_cmd_q.size() + exp_w_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL R2 watchdog actual=hung expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule